// File: doc/BRIEF.md
# Incremental Position Decoder

This block turns the signals of an incremental rotary encoder into a position. It takes the two phase lines A and B, the once-per-turn index line Z and a home switch line H. It keeps three things: a phase count that wraps at a programmable top value, a signed revolution count, and the direction of the last step. Three ways of reading A and B are supported: quadrature, pulse with a direction level, and separate up and down pulse lines.

All four encoder lines pass through two-flop synchronizers, so they may come straight from pins. The revolution count can move in two ways: on each Z edge, or each time the phase count wraps. A Z edge can also reload the phase count with an index value, which corrects accumulated error once per turn. A rising edge on H can clear either count, as selected by a mask. A synchronous clear input holds the revolution count at zero for as long as it stays high.

Top module: `incr_pos_decoder`

## Requirements
- R1: After reset, ph_count, rev_count, dir, a_lvl, b_lvl and z_pulse are all 0.
- R2: With in_mode = 0 (quadrature), each transition of the synchronized {A,B} pair between neighbours of the cycle 00, 10, 11, 01, 00 gives one count. Going forward through that cycle counts up and going backward counts down. A transition that changes A and B together gives no count. Outputs reflect an input change three clock edges after the input is sampled.
- R3: With in_mode = 1 (pulse plus direction), each rising edge of A gives one count. The count is up when B is low and down when B is high. Falling edges of A and changes of B give no count.
- R4: With in_mode = 2, a rising edge of A counts up and a rising edge of B counts down. When both rise in the same cycle there is no count. With in_mode = 3, nothing counts.
- R5: A count up when ph_count is at or above ph_max sets ph_count to 0. ph_max holds the counts per revolution minus one.
- R6: A count down when ph_count is 0 sets ph_count to ph_max.
- R7: dir becomes 0 after a count up and 1 after a count down. a_lvl and b_lvl show the synchronized A and B levels.
- R8: With rev_on_wrap = 0, a rising edge of Z adds 1 to rev_count when dir is 0 and subtracts 1 when dir is 1. Each rising edge of Z gives exactly one cycle of z_pulse.
- R9: With rev_on_wrap = 1, rev_count adds 1 on a wrap from R5 and subtracts 1 on a wrap from R6. Z edges leave rev_count unchanged.
- R10: With zcal_en = 1, a rising edge of Z loads ph_count with ph_index.
- R11: On a rising edge of H, rev_count clears when home_mask bit 0 is set and ph_count clears when bit 1 is set. Bit 2 affects neither count.
- R12: While rev_clr is high, rev_count is 0 and Z edges do not move it. The phase count keeps counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_a | input | 1 | Encoder line A (asynchronous) |
| enc_b | input | 1 | Encoder line B (asynchronous) |
| enc_z | input | 1 | Index line Z (asynchronous) |
| enc_h | input | 1 | Home line H (asynchronous) |
| in_mode | input | 2 | 0 quadrature, 1 pulse+direction, 2 up/down, 3 off |
| ph_max | input | PH_W | Top phase value (counts per revolution minus one) |
| rev_on_wrap | input | 1 | 1: revolution count follows phase wraps; 0: follows Z |
| zcal_en | input | 1 | Z edge reloads the phase count |
| ph_index | input | PH_W | Value loaded on Z when zcal_en is set |
| home_mask | input | 3 | H clears: bit0 revolution count, bit1 phase count, bit2 none |
| rev_clr | input | 1 | Hold revolution count at zero |
| ph_count | output | PH_W | Phase count |
| rev_count | output | REV_W | Revolution count (two's complement) |
| dir | output | 1 | Direction of last count, 1 = down |
| a_lvl | output | 1 | Synchronized A level |
| b_lvl | output | 1 | Synchronized B level |
| z_pulse | output | 1 | One-cycle pulse per Z rising edge |

## Verification
The bench walks a quadrature sequence that covers every forward and reverse neighbour transition. The same sequence includes a diagonal jump, which a decoder that counted it would show as a phase off by one or two. It reaches both wrap points, where a design with an off-by-one compare would stop at ph_max+1 or fail to wrap to ph_max. It checks that the revolution count follows the direction on Z and follows wraps in the other mode; a design that mixed up the two modes would count in both. It also checks the home-mask bits one at a time, with the unused bit on its own, and confirms that the revolution count stays at zero under rev_clr while a Z edge arrives.

// File: rtl/ipd_pkg.sv
package ipd_pkg;
  typedef enum logic [1:0] {
    IN_QUAD      = 2'd0,
    IN_PULSE_DIR = 2'd1,
    IN_UP_DOWN   = 2'd2,
    IN_OFF       = 2'd3
  } in_mode_e;

  // bit positions within the home clear mask
  localparam int HM_REV = 0;
  localparam int HM_PH  = 1;
endpackage

// File: rtl/ipd_sync.sv
module ipd_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ipd_step.sv
module ipd_step
  import ipd_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  in_mode_e mode,
  input  logic     a_s,
  input  logic     b_s,
  input  logic     z_s,
  input  logic     h_s,
  output logic     step_up,
  output logic     step_dn,
  output logic     z_rise,
  output logic     h_rise,
  output logic     a_q,
  output logic     b_q
);
  logic       z_q, h_q;
  logic [1:0] pos_now, pos_old, delta;
  logic       a_up, b_up;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
      z_q <= 1'b0;
      h_q <= 1'b0;
    end else begin
      a_q <= a_s;
      b_q <= b_s;
      z_q <= z_s;
      h_q <= h_s;
    end
  end

  // position of {A,B} around the quadrature cycle 00,10,11,01
  assign pos_now = {b_s, a_s ^ b_s};
  assign pos_old = {b_q, a_q ^ b_q};
  assign delta   = pos_now - pos_old;
  assign a_up    = a_s & ~a_q;
  assign b_up    = b_s & ~b_q;
  assign z_rise  = z_s & ~z_q;
  assign h_rise  = h_s & ~h_q;

  always_comb begin
    step_up = 1'b0;
    step_dn = 1'b0;
    unique case (mode)
      IN_QUAD: begin
        step_up = (delta == 2'd1);
        step_dn = (delta == 2'd3);
      end
      IN_PULSE_DIR: begin
        step_up = a_up & ~b_s;
        step_dn = a_up &  b_s;
      end
      IN_UP_DOWN: begin
        step_up = a_up & ~b_up;
        step_dn = b_up & ~a_up;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ipd_count.sv
module ipd_count
  import ipd_pkg::*;
#(
  parameter int PH_W  = 16,
  parameter int REV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_up,
  input  logic             step_dn,
  input  logic             z_rise,
  input  logic             h_rise,
  input  logic [PH_W-1:0]  ph_max,
  input  logic [PH_W-1:0]  ph_index,
  input  logic             rev_on_wrap,
  input  logic             zcal_en,
  input  logic [2:0]       home_mask,
  input  logic             rev_clr,
  output logic [PH_W-1:0]  ph_count,
  output logic [REV_W-1:0] rev_count,
  output logic             dir,
  output logic             z_pulse
);
  localparam logic [PH_W-1:0]  PH_ONE  = PH_W'(1);
  localparam logic [REV_W-1:0] REV_ONE = REV_W'(1);

  logic            ph_home, ph_cal, take_step, wrap_up, wrap_dn;
  logic [PH_W-1:0] ph_nxt;

  assign ph_home   = h_rise & home_mask[HM_PH];
  assign ph_cal    = z_rise & zcal_en;
  assign take_step = ~ph_home & ~ph_cal;
  assign wrap_up   = take_step & step_up & (ph_count >= ph_max);
  assign wrap_dn   = take_step & step_dn & (ph_count == '0);

  always_comb begin
    ph_nxt = ph_count;
    if (ph_home)                 ph_nxt = '0;
    else if (ph_cal)             ph_nxt = ph_index;
    else if (wrap_up)            ph_nxt = '0;
    else if (wrap_dn)            ph_nxt = ph_max;
    else if (step_up)            ph_nxt = ph_count + PH_ONE;
    else if (step_dn)            ph_nxt = ph_count - PH_ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_count  <= '0;
      rev_count <= '0;
      dir       <= 1'b0;
      z_pulse   <= 1'b0;
    end else begin
      ph_count <= ph_nxt;
      z_pulse  <= z_rise;
      if (step_up)      dir <= 1'b0;
      else if (step_dn) dir <= 1'b1;

      if (rev_clr || (h_rise && home_mask[HM_REV])) begin
        rev_count <= '0;
      end else if (rev_on_wrap) begin
        if (wrap_up)      rev_count <= rev_count + REV_ONE;
        else if (wrap_dn) rev_count <= rev_count - REV_ONE;
      end else if (z_rise) begin
        rev_count <= dir ? rev_count - REV_ONE : rev_count + REV_ONE;
      end
    end
  end
endmodule

// File: rtl/incr_pos_decoder.sv
module incr_pos_decoder
  import ipd_pkg::*;
#(
  parameter int PH_W        = 16,
  parameter int REV_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enc_a,
  input  logic             enc_b,
  input  logic             enc_z,
  input  logic             enc_h,
  input  logic [1:0]       in_mode,
  input  logic [PH_W-1:0]  ph_max,
  input  logic             rev_on_wrap,
  input  logic             zcal_en,
  input  logic [PH_W-1:0]  ph_index,
  input  logic [2:0]       home_mask,
  input  logic             rev_clr,
  output logic [PH_W-1:0]  ph_count,
  output logic [REV_W-1:0] rev_count,
  output logic             dir,
  output logic             a_lvl,
  output logic             b_lvl,
  output logic             z_pulse
);
  localparam int NLINES = 4;

  logic [NLINES-1:0] raw_lines, sync_lines;
  logic step_up, step_dn, z_rise, h_rise;

  assign raw_lines = {enc_h, enc_z, enc_b, enc_a};

  ipd_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_lines),
    .q   (sync_lines)
  );

  ipd_step u_step (
    .clk     (clk),
    .rst     (rst),
    .mode    (in_mode_e'(in_mode)),
    .a_s     (sync_lines[0]),
    .b_s     (sync_lines[1]),
    .z_s     (sync_lines[2]),
    .h_s     (sync_lines[3]),
    .step_up (step_up),
    .step_dn (step_dn),
    .z_rise  (z_rise),
    .h_rise  (h_rise),
    .a_q     (a_lvl),
    .b_q     (b_lvl)
  );

  ipd_count #(.PH_W(PH_W), .REV_W(REV_W)) u_count (
    .clk         (clk),
    .rst         (rst),
    .step_up     (step_up),
    .step_dn     (step_dn),
    .z_rise      (z_rise),
    .h_rise      (h_rise),
    .ph_max      (ph_max),
    .ph_index    (ph_index),
    .rev_on_wrap (rev_on_wrap),
    .zcal_en     (zcal_en),
    .home_mask   (home_mask),
    .rev_clr     (rev_clr),
    .ph_count    (ph_count),
    .rev_count   (rev_count),
    .dir         (dir),
    .z_pulse     (z_pulse)
  );
endmodule

// File: rtl/ipd_checker.sv
module ipd_checker #(
  parameter int PH_W  = 16,
  parameter int REV_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             step_up,
  input logic             step_dn,
  input logic             z_rise,
  input logic             h_rise,
  input logic [PH_W-1:0]  ph_max,
  input logic [PH_W-1:0]  ph_index,
  input logic             zcal_en,
  input logic [2:0]       home_mask,
  input logic             rev_clr,
  input logic [PH_W-1:0]  ph_count,
  input logic [REV_W-1:0] rev_count,
  input logic             dir,
  input logic             z_pulse
);
  logic ph_free;
  assign ph_free = !(h_rise && home_mask[1]) && !(z_rise && zcal_en);

  p_step_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(step_up && step_dn));

  p_wrap_up_r5: assert property (@(posedge clk) disable iff (rst)
    (step_up && ph_free && ph_count >= ph_max) |=> (ph_count == '0));

  p_wrap_dn_r6: assert property (@(posedge clk) disable iff (rst)
    (step_dn && ph_free && ph_count == '0) |=> (ph_count == $past(ph_max)));

  p_dir_up_r7: assert property (@(posedge clk) disable iff (rst)
    step_up |=> !dir);

  p_dir_dn_r7: assert property (@(posedge clk) disable iff (rst)
    step_dn |=> dir);

  p_zpulse_single_r8: assert property (@(posedge clk) disable iff (rst)
    z_pulse |=> !z_pulse);

  p_cal_load_r10: assert property (@(posedge clk) disable iff (rst)
    (z_rise && zcal_en && !(h_rise && home_mask[1])) |=> (ph_count == $past(ph_index)));

  p_home_rev_r11: assert property (@(posedge clk) disable iff (rst)
    (h_rise && home_mask[0]) |=> (rev_count == '0));

  p_rev_hold_r12: assert property (@(posedge clk) disable iff (rst)
    rev_clr |=> (rev_count == '0));
endmodule

bind incr_pos_decoder ipd_checker #(.PH_W(PH_W), .REV_W(REV_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .step_up   (step_up),
  .step_dn   (step_dn),
  .z_rise    (z_rise),
  .h_rise    (h_rise),
  .ph_max    (ph_max),
  .ph_index  (ph_index),
  .zcal_en   (zcal_en),
  .home_mask (home_mask),
  .rev_clr   (rev_clr),
  .ph_count  (ph_count),
  .rev_count (rev_count),
  .dir       (dir),
  .z_pulse   (z_pulse)
);

// File: tb/incr_pos_decoder_test.sv
`timescale 1ns/1ps
module incr_pos_decoder_test;
  localparam int PH_W  = 16;
  localparam int REV_W = 16;
  localparam int NVEC  = 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enc_a = 0, enc_b = 0, enc_z = 0, enc_h = 0;
  logic [1:0] in_mode = 2'd0;
  logic [PH_W-1:0] ph_max = 16'd7;
  logic rev_on_wrap = 1'b0;
  logic zcal_en = 1'b0;
  logic [PH_W-1:0] ph_index = '0;
  logic [2:0] home_mask = 3'b000;
  logic rev_clr = 1'b0;
  logic [PH_W-1:0] ph_count;
  logic [REV_W-1:0] rev_count;
  logic dir, a_lvl, b_lvl, z_pulse;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  incr_pos_decoder #(.PH_W(PH_W), .REV_W(REV_W)) uut (
    .clk(clk), .rst(rst), .enc_a(enc_a), .enc_b(enc_b), .enc_z(enc_z), .enc_h(enc_h),
    .in_mode(in_mode), .ph_max(ph_max), .rev_on_wrap(rev_on_wrap), .zcal_en(zcal_en),
    .ph_index(ph_index), .home_mask(home_mask), .rev_clr(rev_clr),
    .ph_count(ph_count), .rev_count(rev_count), .dir(dir), .a_lvl(a_lvl),
    .b_lvl(b_lvl), .z_pulse(z_pulse)
  );

  // quadrature walk, ph_max = 7: {A, B, expected dir, expected phase}
  localparam logic [10:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 1'b0, 8'd1},
    {1'b1, 1'b1, 1'b0, 8'd2},
    {1'b0, 1'b1, 1'b0, 8'd3},
    {1'b0, 1'b0, 1'b0, 8'd4},
    {1'b0, 1'b1, 1'b1, 8'd3},
    {1'b1, 1'b1, 1'b1, 8'd2},
    {1'b0, 1'b0, 1'b1, 8'd2},
    {1'b1, 1'b0, 1'b0, 8'd3},
    {1'b1, 1'b1, 1'b0, 8'd4},
    {1'b0, 1'b1, 1'b0, 8'd5},
    {1'b0, 1'b0, 1'b0, 8'd6},
    {1'b1, 1'b0, 1'b0, 8'd7},
    {1'b1, 1'b1, 1'b0, 8'd0},
    {1'b1, 1'b0, 1'b1, 8'd7}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive_ab(input logic a, input logic b);
    @(negedge clk);
    enc_a = a;
    enc_b = b;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_z(output int seen);
    seen = 0;
    @(negedge clk);
    enc_z = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (z_pulse) seen++;
    end
    enc_z = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_h();
    @(negedge clk);
    enc_h = 1'b1;
    repeat (4) @(negedge clk);
    enc_h = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int zc;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 ph", ph_count, 0);
    chk("R1 rev", rev_count, 0);
    chk("R1 flags", {dir, a_lvl, b_lvl, z_pulse}, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R2 R5 R6 R7: quadrature walk
    for (int v = 0; v < NVEC; v++) begin
      drive_ab(VEC[v][10], VEC[v][9]);
      chk($sformatf("R2/R5/R6 ph step %0d", v), ph_count, 32'(VEC[v][7:0]));
      chk($sformatf("R7 dir step %0d", v), dir, VEC[v][8]);
      chk($sformatf("R7 levels step %0d", v), {a_lvl, b_lvl}, {VEC[v][10], VEC[v][9]});
    end

    // R8: Z counts by direction (dir = 1 here)
    pulse_z(zc);
    chk("R8 z_pulse count", zc, 1);
    chk("R8 rev down", rev_count, 16'hFFFF);
    drive_ab(1'b1, 1'b1);
    chk("R5 wrap to 0", ph_count, 0);
    chk("R8 wrap ignored in Z mode", rev_count, 16'hFFFF);
    pulse_z(zc);
    chk("R8 rev up", rev_count, 0);

    // R9: revolution from wraps
    rev_on_wrap = 1'b1;
    drive_ab(1'b1, 1'b0);
    chk("R6 wrap to max", ph_count, 7);
    chk("R9 rev on wrap down", rev_count, 16'hFFFF);
    drive_ab(1'b1, 1'b1);
    chk("R9 rev on wrap up", rev_count, 0);
    pulse_z(zc);
    chk("R9 Z ignored", rev_count, 0);

    // R10: index calibration
    ph_index = 16'd5;
    zcal_en = 1'b1;
    pulse_z(zc);
    chk("R10 ph loaded", ph_count, 5);
    zcal_en = 1'b0;

    // R11: home mask
    rev_on_wrap = 1'b0;
    pulse_z(zc);
    chk("R8 rev before home", rev_count, 1);
    home_mask = 3'b100;
    pulse_h();
    chk("R11 bit2 ph", ph_count, 5);
    chk("R11 bit2 rev", rev_count, 1);
    home_mask = 3'b001;
    pulse_h();
    chk("R11 bit0 rev", rev_count, 0);
    chk("R11 bit0 ph kept", ph_count, 5);
    pulse_z(zc);
    home_mask = 3'b010;
    pulse_h();
    chk("R11 bit1 ph", ph_count, 0);
    chk("R11 bit1 rev kept", rev_count, 1);
    home_mask = 3'b000;

    // R12: revolution hold
    @(negedge clk);
    rev_clr = 1'b1;
    repeat (2) @(negedge clk);
    chk("R12 rev cleared", rev_count, 0);
    pulse_z(zc);
    chk("R12 Z blocked", rev_count, 0);
    drive_ab(1'b0, 1'b1);
    chk("R12 phase still counts", ph_count, 1);
    rev_clr = 1'b0;

    // R3: pulse plus direction
    in_mode = 2'd1;
    drive_ab(1'b0, 1'b0);
    chk("R3 B change no count", ph_count, 1);
    drive_ab(1'b1, 1'b0);
    chk("R3 A rise up", ph_count, 2);
    chk("R3 dir up", dir, 0);
    drive_ab(1'b0, 1'b0);
    chk("R3 A fall no count", ph_count, 2);
    drive_ab(1'b0, 1'b1);
    drive_ab(1'b1, 1'b1);
    chk("R3 A rise down", ph_count, 1);
    chk("R3 dir down", dir, 1);
    drive_ab(1'b0, 1'b1);

    // R4: up/down lines and off mode
    in_mode = 2'd2;
    drive_ab(1'b0, 1'b0);
    chk("R4 B fall no count", ph_count, 1);
    drive_ab(1'b1, 1'b0);
    chk("R4 A rise up", ph_count, 2);
    drive_ab(1'b0, 1'b0);
    drive_ab(1'b0, 1'b1);
    chk("R4 B rise down", ph_count, 1);
    chk("R4 dir", dir, 1);
    drive_ab(1'b0, 1'b0);
    drive_ab(1'b1, 1'b1);
    chk("R4 both rise cancel", ph_count, 1);
    drive_ab(1'b0, 1'b0);
    in_mode = 2'd3;
    drive_ab(1'b1, 1'b0);
    chk("R4 off mode", ph_count, 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule